// File: doc/BRIEF.md
# DMA Request-to-Channel Router

This block routes a wide bank of peripheral request lines onto a smaller set of DMA channels. Each request line owns one 8-bit routing entry that holds an enable flag and a target channel number. Software programs the entries through a simple register port addressed by byte offset. The first 64 entries sit in one address window, and the remaining entries sit in a second window higher up. A write that enables a route to a channel the block does not have is rejected and reported.

Every request line is first brought into the clock domain by a synchronizer. Each enabled line then contributes to the request level of its target channel. When several enabled lines point at one channel, their levels are ORed together. The block watches each channel level and emits a one-cycle event when the level rises (a request arrived while the channel was idle) and another when it falls (the end of a receive burst). Channel status storage and the data mover itself sit downstream and consume these levels and pulses.

Top module: `dreq_chan_mapper`

## Requirements
- R1: After reset every routing entry reads as zero (route disabled), and every channel level, rise event and fall event output is low.
- R2: A routing entry is 8 bits. Bit 7 enables the route and bits 4:0 name the target channel. Bits 6:5 are stored and read back unchanged. Write data bits 31:8 are ignored, and reads return the entry zero-extended to 32 bits.
- R3: The entry for request n (n below 64) sits at byte offset 0x100 + 4n. The entry for request n (64 to 74) sits at 0x1100 + 4(n-64). Any other offset, including offsets not aligned to 4 bytes, reads as zero, and a write to it changes no entry.
- R4: A write that sets bit 7 with a channel number of NUM_CH or more leaves the entry unchanged, and `reg_err` is high for exactly the cycle after the write. A write of such a channel number with bit 7 clear is stored without error.
- R5: When a channel level goes from low to high, `ch_rise_evt` for that channel is high for exactly the one cycle in which `ch_level` first shows high. A change on `req_in` reaches `ch_level` on the third rising clock edge after it is applied (two synchronizer stages, then the level register).
- R6: When a channel level goes from high to low, `ch_fall_evt` for that channel is high for exactly the one cycle in which `ch_level` first shows low.
- R7: A channel level is the OR of all enabled request lines routed to it. While one routed line stays active, a second line rising or falling causes no event on that channel.
- R8: A request line whose entry has bit 7 clear has no effect on any channel level or event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read enable |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the offset |
| reg_err | output | 1 | One-cycle pulse when a route to a nonexistent channel is rejected |
| req_in | input | NUM_REQ | Peripheral request lines, asynchronous |
| ch_level | output | NUM_CH | Live request level per channel |
| ch_rise_evt | output | NUM_CH | Request-after-idle pulse per channel |
| ch_fall_evt | output | NUM_CH | End-of-receive pulse per channel |

## Verification
The case hardest to reach from the ports is a shared channel. Two enabled lines, one in each address window, target the same channel, and the second line's edges must raise no event while the first line holds the level. The stimulus routes request 0 and request 64 to one channel, raises them in staggered order and releases them in staggered order. Every sampled cycle in between is checked for silence, and only the final release may produce a fall pulse. Timing is pinned down by sampling the channel level one edge before and exactly at the third edge after an input change.

// File: rtl/dreq_map_pkg.sv
package dreq_map_pkg;
   localparam int MAP_W      = 8;
   localparam int CH_FIELD_W = 5;

   // bit 7 enable, bits 6:5 spare (kept), bits 4:0 target channel
   typedef struct packed {
      logic                  en;
      logic [1:0]            spare;
      logic [CH_FIELD_W-1:0] chan;
   } route_t;

   localparam route_t ROUTE_RESET = '0;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 1) begin : g_bad
      $error("dreq_sync: STAGES must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= async_i;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dreq_route_regs.sv
module dreq_route_regs
   import dreq_map_pkg::*;
#(
   parameter int NUM_REQ = 75,
   parameter int NUM_CH  = 16,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int LO_BASE = 'h100,
   parameter int LO_CNT  = 64,
   parameter int HI_BASE = 'h1100
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    wr_i,
   input  logic                                    rd_i,
   input  logic [ADDR_W-1:0]                       addr_i,
   input  logic [DATA_W-1:0]                       wdata_i,
   output logic [DATA_W-1:0]                       rdata_o,
   output logic                                    err_o,
   output logic [NUM_REQ-1:0]                      en_o,
   output logic [NUM_REQ-1:0][CH_FIELD_W-1:0]      chan_o
);
   localparam int LO_EFF = (NUM_REQ < LO_CNT) ? NUM_REQ : LO_CNT;
   localparam int HI_CNT = NUM_REQ - LO_EFF;
   localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

   if (DATA_W < MAP_W) begin : g_bad_data
      $error("dreq_route_regs: DATA_W narrower than a routing entry");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("dreq_route_regs: ADDR_W too small");
   end

   route_t            route_q [NUM_REQ];
   logic              lo_hit, hi_hit, hit;
   logic [IDX_W-1:0]  lo_idx, hi_idx, idx;
   logic [ADDR_W-1:0] lo_off;
   logic              aligned;

   assign aligned = (addr_i[1:0] == 2'b00);
   assign lo_off  = addr_i - ADDR_W'(LO_BASE);
   assign lo_hit  = aligned && (addr_i >= ADDR_W'(LO_BASE)) &&
                    (lo_off < ADDR_W'(4 * LO_EFF));
   assign lo_idx  = IDX_W'(lo_off >> 2);

   // upper window exists only when requests spill past the lower one
   if (HI_CNT > 0) begin : g_hi_win
      logic [ADDR_W-1:0] hi_off;
      assign hi_off = addr_i - ADDR_W'(HI_BASE);
      assign hi_hit = aligned && (addr_i >= ADDR_W'(HI_BASE)) &&
                      (hi_off < ADDR_W'(4 * HI_CNT));
      assign hi_idx = IDX_W'(LO_EFF) + IDX_W'(hi_off >> 2);
   end else begin : g_no_hi_win
      assign hi_hit = 1'b0;
      assign hi_idx = '0;
   end

   assign hit = lo_hit || hi_hit;
   assign idx = lo_hit ? lo_idx : hi_idx;

   route_t wr_entry;
   logic   bad_chan, do_store;

   assign wr_entry = route_t'(wdata_i[MAP_W-1:0]);
   assign bad_chan = wr_entry.en &&
                     ({1'b0, wr_entry.chan} >= (CH_FIELD_W+1)'(NUM_CH));
   assign do_store = wr_i && hit && !bad_chan;

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^wdata_i[DATA_W-1:MAP_W];

   for (genvar r = 0; r < NUM_REQ; r++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            route_q[r] <= ROUTE_RESET;
         else if (do_store && (idx == IDX_W'(r)))
            route_q[r] <= wr_entry;
      end
      assign en_o[r]   = route_q[r].en;
      assign chan_o[r] = route_q[r].chan;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_o <= 1'b0;
      else        err_o <= wr_i && hit && bad_chan;
   end

   always_comb begin
      rdata_o = '0;
      if (rd_i && hit)
         rdata_o[MAP_W-1:0] = route_q[idx];
   end
endmodule

// File: rtl/dreq_chan_merge.sv
module dreq_chan_merge
   import dreq_map_pkg::*;
#(
   parameter int NUM_REQ = 75,
   parameter int NUM_CH  = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_REQ-1:0]                 req_i,
   input  logic [NUM_REQ-1:0]                 en_i,
   input  logic [NUM_REQ-1:0][CH_FIELD_W-1:0] chan_i,
   output logic [NUM_CH-1:0]                  level_o,
   output logic [NUM_CH-1:0]                  rise_o,
   output logic [NUM_CH-1:0]                  fall_o
);
   logic [NUM_CH-1:0] level_d;

   // per channel: OR of every enabled line routed here
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [NUM_REQ-1:0] hits;
      for (genvar r = 0; r < NUM_REQ; r++) begin : g_line
         assign hits[r] = req_i[r] && en_i[r] && (chan_i[r] == CH_FIELD_W'(c));
      end
      assign level_d[c] = |hits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_o <= '0;
         rise_o  <= '0;
         fall_o  <= '0;
      end else begin
         level_o <= level_d;
         rise_o  <= level_d & ~level_o;
         fall_o  <= ~level_d & level_o;
      end
   end
endmodule

// File: rtl/dreq_chan_mapper.sv
module dreq_chan_mapper
   import dreq_map_pkg::*;
#(
   parameter int NUM_REQ     = 75,
   parameter int NUM_CH      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int LO_BASE     = 'h100,
   parameter int LO_CNT      = 64,
   parameter int HI_BASE     = 'h1100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               reg_err,
   input  logic [NUM_REQ-1:0] req_in,
   output logic [NUM_CH-1:0]  ch_level,
   output logic [NUM_CH-1:0]  ch_rise_evt,
   output logic [NUM_CH-1:0]  ch_fall_evt
);
   if (NUM_CH < 1 || NUM_CH > (1 << CH_FIELD_W)) begin : g_bad_ch
      $error("dreq_chan_mapper: NUM_CH out of range for a 5-bit channel field");
   end
   if (NUM_REQ < 1) begin : g_bad_req
      $error("dreq_chan_mapper: NUM_REQ must be positive");
   end
   if (HI_BASE < LO_BASE + 4 * LO_CNT) begin : g_bad_win
      $error("dreq_chan_mapper: upper window overlaps lower window");
   end

   logic [NUM_REQ-1:0]                 req_s;
   logic [NUM_REQ-1:0]                 route_en;
   logic [NUM_REQ-1:0][CH_FIELD_W-1:0] route_chan;

   if (SYNC_STAGES == 0) begin : g_no_sync
      assign req_s = req_in;
   end else begin : g_sync
      dreq_sync #(.WIDTH(NUM_REQ), .STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_i (req_in),
         .sync_o  (req_s)
      );
   end

   dreq_route_regs #(
      .NUM_REQ (NUM_REQ), .NUM_CH (NUM_CH), .ADDR_W (ADDR_W),
      .DATA_W  (DATA_W),  .LO_BASE(LO_BASE), .LO_CNT(LO_CNT),
      .HI_BASE (HI_BASE)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (reg_wr),
      .rd_i    (reg_rd),
      .addr_i  (reg_addr),
      .wdata_i (reg_wdata),
      .rdata_o (reg_rdata),
      .err_o   (reg_err),
      .en_o    (route_en),
      .chan_o  (route_chan)
   );

   dreq_chan_merge #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req_s),
      .en_i    (route_en),
      .chan_i  (route_chan),
      .level_o (ch_level),
      .rise_o  (ch_rise_evt),
      .fall_o  (ch_fall_evt)
   );
endmodule

// File: rtl/dreq_chan_mapper_chk.sv
module dreq_chan_mapper_chk #(
   parameter int NUM_CH = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_err,
   input logic [NUM_CH-1:0] ch_level,
   input logic [NUM_CH-1:0] ch_rise_evt,
   input logic [NUM_CH-1:0] ch_fall_evt
);
   // R5
   rise_on_upturn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_rise_evt & ~(ch_level & ~$past(ch_level))) == '0);

   // R6
   fall_on_downturn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_fall_evt & ~(~ch_level & $past(ch_level))) == '0);

   // R7
   every_change_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_level ^ $past(ch_level)) == (ch_rise_evt | ch_fall_evt));

   // R4
   err_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_err |-> $past(reg_wr));

   // R4
   err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_err |=> !reg_err || $past(reg_wr));
endmodule

bind dreq_chan_mapper dreq_chan_mapper_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_err     (reg_err),
   .ch_level    (ch_level),
   .ch_rise_evt (ch_rise_evt),
   .ch_fall_evt (ch_fall_evt)
);

// File: tb/tb_dreq_chan_mapper.sv
module tb_dreq_chan_mapper;
   localparam int NUM_REQ = 75;
   localparam int NUM_CH  = 16;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               reg_wr = 1'b0;
   logic               reg_rd = 1'b0;
   logic [15:0]        reg_addr = '0;
   logic [31:0]        reg_wdata = '0;
   logic [31:0]        reg_rdata;
   logic               reg_err;
   logic [NUM_REQ-1:0] req_in = '0;
   logic [NUM_CH-1:0]  ch_level, ch_rise_evt, ch_fall_evt;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   dreq_chan_mapper #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_err(reg_err), .req_in(req_in), .ch_level(ch_level),
      .ch_rise_evt(ch_rise_evt), .ch_fall_evt(ch_fall_evt)
   );

   // {offset[15:0], wdata[7:0], expect err, expect readback[7:0]}
   localparam logic [32:0] VEC [9] = '{
      {16'h0100, 8'h83, 1'b0, 8'h83},  // R2 R3 req0 -> ch3
      {16'h0104, 8'h85, 1'b0, 8'h85},  // R3 req1 -> ch5
      {16'h1100, 8'h83, 1'b0, 8'h83},  // R3 req64 -> ch3
      {16'h1128, 8'hEA, 1'b0, 8'hEA},  // R2 spare bits kept, req74 -> ch10
      {16'h01FC, 8'h01, 1'b0, 8'h01},  // R8 req63 route disabled
      {16'h0108, 8'h94, 1'b1, 8'h00},  // R4 ch20 enabled: rejected
      {16'h010C, 8'h14, 1'b0, 8'h14},  // R4 ch20 disabled: stored
      {16'h112C, 8'h81, 1'b0, 8'h00},  // R3 past last entry
      {16'h0111, 8'h81, 1'b0, 8'h00}   // R3 misaligned
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic do_write(input logic [15:0] a, input logic [31:0] d, output logic err);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
      err = reg_err;
   endtask

   task automatic do_read(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      reg_rd = 1'b0;
   endtask

   // apply at a falling edge, wait three rising edges, sample at the next fall
   task automatic set_req(input int line, input logic v);
      @(negedge clk);
      req_in[line] = v;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic quiet(input int n, output logic [NUM_CH-1:0] seen);
      seen = '0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         seen |= ch_rise_evt | ch_fall_evt;
      end
   endtask

   initial begin
      logic        e;
      logic [31:0] d;
      logic [NUM_CH-1:0] seen;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 level", 32'(ch_level), 0);
      chk("R1 events", 32'(ch_rise_evt | ch_fall_evt), 0);
      do_read(16'h0100, d); chk("R1 entry0", d, 0);
      rst_n = 1'b1;
      do_read(16'h1128, d); chk("R1 entry74", d, 0);

      for (int i = 0; i < 9; i++) begin
         do_write(VEC[i][32:17], {24'hFFFFFF, VEC[i][16:9]}, e);
         chk($sformatf("R4 err vec%0d", i), 32'(e), 32'(VEC[i][8]));
         do_read(VEC[i][32:17], d);
         chk($sformatf("R2/R3 readback vec%0d", i), d, 32'(VEC[i][7:0]));
      end
      @(negedge clk);
      chk("R4 err one cycle", 32'(reg_err), 0);
      do_read(16'h0110, d); chk("R3 misaligned write left entry4", d, 0);
      do_read(16'h0200, d); chk("R3 gap reads zero", d, 0);

      // R5 timing on req1 -> ch5
      @(negedge clk);
      req_in[1] = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R5 not yet after two edges", 32'(ch_level[5]), 0);
      @(negedge clk);
      chk("R5 level at third edge", 32'(ch_level), 32'h20);
      chk("R5 rise pulse", 32'(ch_rise_evt), 32'h20);
      @(negedge clk);
      chk("R5 rise one cycle", 32'(ch_rise_evt), 0);
      set_req(1, 1'b0);
      chk("R6 fall pulse", 32'(ch_fall_evt), 32'h20);
      chk("R6 level low", 32'(ch_level), 0);
      @(negedge clk);
      chk("R6 fall one cycle", 32'(ch_fall_evt), 0);

      // R7 shared ch3 from both windows
      set_req(0, 1'b1);
      chk("R7 first line rise", 32'(ch_rise_evt), 32'h8);
      @(negedge clk);
      req_in[64] = 1'b1;
      quiet(6, seen); chk("R7 second rise silent", 32'(seen), 0);
      chk("R7 level held", 32'(ch_level), 32'h8);
      @(negedge clk);
      req_in[0] = 1'b0;
      quiet(6, seen); chk("R7 first release silent", 32'(seen), 0);
      chk("R7 level still held", 32'(ch_level), 32'h8);
      set_req(64, 1'b0);
      chk("R7 last release falls", 32'(ch_fall_evt), 32'h8);

      // R2 upper-window entry with spare bits: req74 -> ch10
      set_req(74, 1'b1);
      chk("R2 req74 routes ch10", 32'(ch_level), 32'h400);
      set_req(74, 1'b0);

      // R8 disabled routes
      @(negedge clk);
      req_in[63] = 1'b1; req_in[3] = 1'b1; req_in[2] = 1'b1;
      quiet(8, seen);
      chk("R8 disabled lines no event", 32'(seen), 0);
      chk("R8 disabled lines no level", 32'(ch_level), 0);
      req_in = '0;
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule